// File: doc/BRIEF.md
# Bus Write Tag Capture Unit

This block watches a processor bus and picks out software instrumentation writes. Firmware marks the start and end of each function by storing a tag word to one fixed address. When the address, the status field and the write strobe all match the programmed values, the block takes a time-stamped record. The upper half of the written word is read as an entry or exit marker, and the lower half names the function.

Records go into a small first-in first-out buffer. A consumer drains the buffer through a valid/ready stream, and each record carries the cycle count at which the write was seen. Software can then measure how long each function takes between entry and exit.

Capture runs only while the arm input is high. When the buffer is full, new records are discarded and a sticky overflow flag is raised.

Top module: `tag_capture`

## Requirements
- R1: After the asynchronous reset, rec_valid_o is 0, fill_o is 0, ovf_o is 0 and the timestamp counter is 0.
- R2: A record is captured at a rising clock edge only when all of the following hold: bus_wr_i is 1, bus_addr_i equals tag_addr_i, and bus_status_i equals all 16 bits of wr_code_i. Any other write stores nothing.
- R3: While arm_i is 0, no record is captured, whatever the bus does.
- R4: The timestamp is a 32-bit cycle counter. It starts at 0 after reset, adds 1 on every clock edge and wraps modulo 2^32. A record holds the counter value present at its capture edge.
- R5: rec_kind_o is 2'b01 (entry) when data bits [31:16] are 0xAAAA, 2'b10 (exit) when they are 0x5555, and 2'b00 (unknown) for any other value. Unknown tags are still stored.
- R6: rec_id_o equals data bits [15:0] of the captured write. These bits play no part in deciding whether a write is captured.
- R7: The buffer holds FIFO_DEPTH (16) records and releases them in capture order. rec_valid_o is 1 exactly when the buffer is not empty. A record is removed on an edge where both rec_valid_o and rec_ready_i are 1. A captured record appears at the output in the cycle after its capture edge.
- R8: When the buffer is full at a capture edge, the new record is discarded, even if a record is removed at that same edge. ovf_o is then set and stays at 1 until reset.
- R9: fill_o always equals the number of records held in the buffer.
- R10: The match address and the status code are taken live from tag_addr_i and wr_code_i. After either one changes, writes that match the old value are no longer captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Capture enable |
| tag_addr_i | input | 32 | Address that tag writes must hit |
| wr_code_i | input | 16 | Status value that marks a data write |
| bus_addr_i | input | 32 | Observed address bus |
| bus_data_i | input | 32 | Observed data bus |
| bus_status_i | input | 16 | Observed status field |
| bus_wr_i | input | 1 | Observed write strobe |
| rec_valid_o | output | 1 | A record is available at the output |
| rec_ready_i | input | 1 | Consumer accepts the current record |
| rec_ts_o | output | 32 | Timestamp of the current record |
| rec_id_o | output | 16 | Function identifier of the current record |
| rec_kind_o | output | 2 | 01 entry, 10 exit, 00 unknown |
| fill_o | output | 5 | Number of records held in the buffer |
| ovf_o | output | 1 | Sticky flag: at least one record was dropped |

## Verification
The state inside this block shows at the ports directly. A wrong read or write pointer shows up as a record out of order, or as a stale record, at the next handshake. A wrong occupancy count shows in fill_o, and in rec_valid_o, in the very next cycle. A drifting timestamp counter makes every later record differ from the cycle count the bench keeps for itself. An overflow bit that is not set, or that clears, is seen at ovf_o in the cycle after the write that was dropped.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TS_W = 32;
  localparam int ID_W = 16;
  localparam logic [15:0] MARK_ENTRY = 16'hAAAA;
  localparam logic [15:0] MARK_EXIT  = 16'h5555;

  typedef enum logic [1:0] {
    KIND_UNK   = 2'b00,
    KIND_ENTRY = 2'b01,
    KIND_EXIT  = 2'b10
  } tag_kind_e;

  typedef struct packed {
    logic [TS_W-1:0] ts;
    logic [ID_W-1:0] id;
    tag_kind_e       kind;
  } tag_rec_t;
endpackage

// File: rtl/tc_stamp.sv
module tc_stamp #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] ts_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign ts_o = cnt_q;

  AST_TS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
endmodule

// File: rtl/tc_match.sv
module tc_match
  import tc_pkg::*;
(
  input  logic        arm_i,
  input  logic [31:0] tag_addr_i,
  input  logic [15:0] wr_code_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] data_i,
  input  logic [15:0] status_i,
  input  logic        strb_i,
  output logic        hit_o,
  output tag_kind_e   kind_o,
  output logic [15:0] id_o
);
  logic addr_eq, stat_eq;

  assign addr_eq = (addr_i == tag_addr_i);
  assign stat_eq = (status_i == wr_code_i);
  assign hit_o   = arm_i & strb_i & addr_eq & stat_eq;
  assign id_o    = data_i[15:0];

  always_comb begin
    if (data_i[31:16] == MARK_ENTRY)     kind_o = KIND_ENTRY;
    else if (data_i[31:16] == MARK_EXIT) kind_o = KIND_EXIT;
    else                                 kind_o = KIND_UNK;
  end
endmodule

// File: rtl/tc_fifo.sv
module tc_fifo #(
  parameter  int DW    = 50,
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // full is judged before any same-edge pop
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1
              || cnt_q + 1'b1 == $past(cnt_q))); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R7
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_q == CW'(DEPTH)) |=> (ovf_o && cnt_q <= $past(cnt_q))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R8
endmodule

// File: rtl/tag_capture.sv
module tag_capture
  import tc_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [31:0]      tag_addr_i,
  input  logic [15:0]      wr_code_i,
  input  logic [31:0]      bus_addr_i,
  input  logic [31:0]      bus_data_i,
  input  logic [15:0]      bus_status_i,
  input  logic             bus_wr_i,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  output logic [31:0]      rec_ts_o,
  output logic [15:0]      rec_id_o,
  output logic [1:0]       rec_kind_o,
  output logic [CNT_W-1:0] fill_o,
  output logic             ovf_o
);
  localparam int REC_W = $bits(tag_rec_t);

  logic [TS_W-1:0]  ts;
  logic             hit;
  tag_kind_e        kind;
  logic [ID_W-1:0]  id;
  tag_rec_t         rec_in, rec_out;
  logic [REC_W-1:0] rec_out_raw;

  tc_stamp #(.W(TS_W)) i_stamp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ts_o   (ts)
  );

  tc_match i_match (
    .arm_i      (arm_i),
    .tag_addr_i (tag_addr_i),
    .wr_code_i  (wr_code_i),
    .addr_i     (bus_addr_i),
    .data_i     (bus_data_i),
    .status_i   (bus_status_i),
    .strb_i     (bus_wr_i),
    .hit_o      (hit),
    .kind_o     (kind),
    .id_o       (id)
  );

  always_comb begin
    rec_in.ts   = ts;
    rec_in.id   = id;
    rec_in.kind = kind;
  end

  tc_fifo #(.DW(REC_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (hit),
    .data_i  (rec_in),
    .pop_i   (rec_ready_i),
    .valid_o (rec_valid_o),
    .data_o  (rec_out_raw),
    .count_o (fill_o),
    .ovf_o   (ovf_o)
  );

  assign rec_out    = tag_rec_t'(rec_out_raw);
  assign rec_ts_o   = rec_out.ts;
  assign rec_id_o   = rec_out.id;
  assign rec_kind_o = rec_out.kind;

  AST_DISARMED_NO_GROWTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (fill_o <= $past(fill_o))); // R3
  AST_VALID_MATCHES_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o == (fill_o != '0)); // R7
  AST_KIND_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_kind_o != 2'b11)); // R5
endmodule

// File: tb/test_tag_capture.sv
module test_tag_capture;
  typedef struct {
    logic [31:0] ts;
    logic [15:0] id;
    logic [1:0]  kind;
  } exp_rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [31:0] tag_addr = 32'hAABB0000;
  logic [15:0] wr_code = 16'h0001;
  logic [31:0] b_addr = '0;
  logic [31:0] b_data = '0;
  logic [15:0] b_stat = '0;
  logic        b_wr = 1'b0;
  logic        ready = 1'b0;
  logic        v;
  logic [31:0] ts_o;
  logic [15:0] id_o;
  logic [1:0]  kind_o;
  logic [4:0]  fill;
  logic        ovf;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] tb_ts;
  bit          m_ovf;
  exp_rec_t    q[$];

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_ts <= '0;
    else        tb_ts <= tb_ts + 1;

  tag_capture i_tag_capture (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .tag_addr_i(tag_addr),
    .wr_code_i(wr_code), .bus_addr_i(b_addr), .bus_data_i(b_data),
    .bus_status_i(b_stat), .bus_wr_i(b_wr), .rec_valid_o(v),
    .rec_ready_i(ready), .rec_ts_o(ts_o), .rec_id_o(id_o),
    .rec_kind_o(kind_o), .fill_o(fill), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] kind_of(input logic [15:0] up);
    if (up == 16'hAAAA) return 2'b01;
    if (up == 16'h5555) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check_outs();
    chk("R7 valid", 32'(v), 32'(q.size() != 0));
    chk("R9 fill", 32'(fill), 32'(q.size()));
    chk("R8 ovf", 32'(ovf), 32'(m_ovf));
    if (q.size() != 0 && v) begin
      chk("R4 ts", ts_o, q[0].ts);
      chk("R6 id", 32'(id_o), 32'(q[0].id));
      chk("R5 kind", 32'(kind_o), 32'(q[0].kind));
    end
  endtask

  // called at a negedge: checks, drives, models the next edge
  task automatic step(input logic [31:0] a, input logic [31:0] d, input logic [15:0] s,
                      input logic w, input logic ar, input logic rdy);
    bit hit, full;
    check_outs();
    b_addr = a; b_data = d; b_stat = s; b_wr = w; arm = ar; ready = rdy;
    hit  = w && ar && (a == tag_addr) && (s == wr_code);
    full = (q.size() == 16);
    if (rdy && q.size() != 0) void'(q.pop_front());
    if (hit) begin
      if (full) m_ovf = 1'b1;
      else q.push_back('{ts: tb_ts, id: d[15:0], kind: kind_of(d[31:16])});
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; b_wr = 1'b0; arm = 1'b0; ready = 1'b0;
    q.delete(); m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic rdy);
    for (int i = 0; i < n; i++) step('0, '0, '0, 1'b0, 1'b1, rdy);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(1234));
    do_reset();
    // R1 reset state
    chk("R1 valid", 32'(v), 0);
    chk("R1 fill", 32'(fill), 0);
    chk("R1 ovf", 32'(ovf), 0);
    chk("R1 ts", tb_ts, 32'd1);

    step(tag_addr, 32'hAAAA03E7, wr_code, 1, 1, 0);
    step(tag_addr, 32'hAAAA0001, 16'h0002, 1, 1, 0);  // wrong status
    step(32'hAABB0004, 32'hAAAA0002, wr_code, 1, 1, 0); // wrong address
    step(tag_addr, 32'hAAAA0003, wr_code, 0, 1, 0);   // no strobe
    chk("R2 fill", 32'(fill), 1);
    step(tag_addr, 32'h555503E7, wr_code, 1, 0, 0);   // disarmed
    step('0, '0, '0, 0, 1, 0);
    chk("R3 fill", 32'(fill), 1);
    step(tag_addr, 32'h555503E7, wr_code, 1, 1, 0);
    step(tag_addr, 32'h1234045A, wr_code, 1, 1, 0);   // unknown kind
    idle(5, 1);

    // R8 overflow, including a full edge with a same-edge pop
    for (int i = 0; i < 16; i++) step(tag_addr, 32'hAAAA0000 | 32'(i), wr_code, 1, 1, 0);
    step(tag_addr, 32'h5555BEEF, wr_code, 1, 1, 1);
    chk("R8 ovf", 32'(ovf), 1);
    step(tag_addr, 32'h5555CAFE, wr_code, 1, 1, 0);
    idle(20, 1);
    chk("R8 sticky", 32'(ovf), 1);

    // R10 retarget
    do_reset();
    tag_addr = 32'h12340000; wr_code = 16'h00A5;
    step(32'hAABB0000, 32'hAAAA0011, 16'h0001, 1, 1, 0);
    step('0, '0, '0, 0, 1, 0);
    chk("R10 old", 32'(fill), 0);
    step(32'h12340000, 32'h55550022, 16'h00A5, 1, 1, 0);
    step('0, '0, '0, 0, 1, 0);
    chk("R10 new", 32'(fill), 1);
    chk("R10 id", 32'(id_o), 32'h0022);
    idle(3, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, d;
      logic [15:0] s, up;
      int r;
      r  = $urandom_range(0, 2);
      up = (r == 0) ? 16'hAAAA : (r == 1) ? 16'h5555 : 16'($urandom);
      d  = {up, 16'($urandom)};
      a  = ($urandom_range(0, 9) < 6) ? tag_addr : $urandom;
      s  = ($urandom_range(0, 9) < 7) ? wr_code : 16'($urandom);
      step(a, d, s, $urandom_range(0, 9) < 7, $urandom_range(0, 9) < 9,
           $urandom_range(0, 9) < ((i / 500) % 2 ? 7 : 3));
    end
    idle(20, 1);
    finish_run();
  end
endmodule